// File: doc/BRIEF.md
# Endian-Selectable Byte-Addressed Data Memory

This block is a small synchronous data store. Every address selects one 8-bit byte, and a request reads or writes either a single byte or a 32-bit word of four consecutive bytes. A word may start only on an address whose two low bits are zero. A word request at any other address is refused: the error flag rises and nothing is stored.

A mode input chooses, separately for each request, how the four bytes of a word map onto the lowest through highest addresses. In big-endian order the most significant byte goes to the lowest address. In little-endian order the least significant byte goes there. Byte requests do not depend on the mode.

Internally the bytes are held in four banks, one per position within a word. Lane steering routes the bytes between the 32-bit data path and the banks. Read data and the error flag are registered and appear one clock after the request.

Top module: `endian_byte_mem`

## Requirements
- R1: Each address names one byte. A word request (`req_size`=1) covers addresses A..A+3 and is legal only when A[1:0]==0. A byte request (`req_size`=0) covers address A alone.
- R2: With `big_endian`=1, a legal word access maps address A+k (k=0..3) to data bits [31-8k:24-8k].
- R3: With `big_endian`=0, a legal word access maps address A+k (k=0..3) to data bits [8k+7:8k].
- R4: A word read or write with A[1:0]!=0 sets `rsp_err` for the single following cycle and leaves every stored byte unchanged. Back-to-back faulting requests give one error cycle each. Any other cycle gives `rsp_err`=0.
- R5: A faulting word read loads 0 into `rsp_rdata`.
- R6: A byte request never raises `rsp_err`. A byte read returns the stored byte in bits [7:0] with bits [31:8] zero.
- R7: A byte write changes only the addressed byte, taken from `req_wdata[7:0]`.
- R8: `rsp_rdata` is loaded on the clock edge that samples `req_rd`, is visible from the next cycle, and holds its value in cycles without a read.
- R9: A write takes effect on the edge that samples `req_wr`. A read in the same cycle returns the contents from before that write, and a read in a later cycle sees the new contents.
- R10: The mode is sampled on every request. A word written in one mode and read back in the other comes back with its byte order reversed.
- R11: While reset is applied and after its release, `rsp_rdata` and `rsp_err` read 0 until the first request.
- R12: Byte reads and byte writes give the same result whatever the value of `big_endian`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_rd | input | 1 | Read strobe |
| req_wr | input | 1 | Write strobe |
| req_size | input | 1 | Access size: 0 byte, 1 word |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data; a byte write uses bits [7:0] |
| big_endian | input | 1 | 1 big-endian, 0 little-endian byte order within a word |
| rsp_rdata | output | 32 | Registered read data |
| rsp_err | output | 1 | Registered misalignment flag |

## Verification
The byte banks hold the only long-lived state. A wrong bank write enable or a byte placed in the wrong lane stays hidden until that byte is read. The bench therefore re-reads each region it has just changed. It reads whole words in both byte orders and reads single bytes at every offset, so a misplaced byte shows up as a data mismatch one cycle after the read. A fault that wrongly reaches storage shows up the same way on the next read of the neighbouring aligned word. The error and read-data registers are compared on every cycle, so a wrong value in either one is caught in the cycle right after the request that caused it.

// File: rtl/emem_pkg.sv
package emem_pkg;

  localparam int unsigned LANES  = 4;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned WORD_W = LANES * BYTE_W;
  localparam int unsigned LANE_W = $clog2(LANES);

  typedef enum logic {
    SZ_BYTE = 1'b0,
    SZ_WORD = 1'b1
  } acc_size_e;

  // Bit position of the byte held at offset 'lane' of a word, for the chosen order.
  function automatic int unsigned lane_lsb(input int unsigned lane, input logic big);
    return big ? (LANES - 1 - lane) * BYTE_W : lane * BYTE_W;
  endfunction

endpackage

// File: rtl/emem_align_chk.sv
module emem_align_chk
  import emem_pkg::*;
(
  input  logic              req_rd,
  input  logic              req_wr,
  input  acc_size_e         req_size,
  input  logic [LANE_W-1:0] addr_lo,
  output logic              rd_ok,
  output logic              wr_ok,
  output logic              fault
);

  logic misplaced;

  always_comb begin
    misplaced = (req_size == SZ_WORD) && (addr_lo != '0);
    rd_ok     = req_rd && !misplaced;
    wr_ok     = req_wr && !misplaced;
    fault     = (req_rd || req_wr) && misplaced;
  end

endmodule

// File: rtl/emem_lane_map.sv
module emem_lane_map
  import emem_pkg::*;
(
  input  acc_size_e                     req_size,
  input  logic                          big,
  input  logic [LANE_W-1:0]             lane,
  input  logic                          wr_ok,
  input  logic [WORD_W-1:0]             wdata,
  input  logic [LANES-1:0][BYTE_W-1:0]  bank_q,
  output logic [LANES-1:0]              bank_we,
  output logic [LANES-1:0][BYTE_W-1:0]  bank_d,
  output logic [WORD_W-1:0]             rd_word
);

  // Write steering: a word spreads over all lanes, a byte goes to one lane.
  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      if (req_size == SZ_WORD) begin
        bank_d[k]  = wdata[lane_lsb(k, big) +: BYTE_W];
        bank_we[k] = wr_ok;
      end else begin
        bank_d[k]  = wdata[BYTE_W-1:0];
        bank_we[k] = wr_ok && (lane == LANE_W'(k));
      end
    end
  end

  // Read steering: gather the lanes in the chosen order, or zero-extend one byte.
  always_comb begin
    rd_word = '0;
    if (req_size == SZ_WORD) begin
      for (int k = 0; k < LANES; k++)
        rd_word[lane_lsb(k, big) +: BYTE_W] = bank_q[k];
    end else begin
      rd_word[BYTE_W-1:0] = bank_q[lane];
    end
  end

  always_comb begin
    if (!$isunknown(bank_we) && req_size == SZ_BYTE)
      a_byte_single_lane_r7: assert ($countones(bank_we) <= 1);
  end

endmodule

// File: rtl/emem_bank.sv
module emem_bank
  import emem_pkg::*;
#(
  parameter int unsigned IDX_W = 4
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [BYTE_W-1:0] d,
  output logic [BYTE_W-1:0] q
);

  localparam int unsigned ROWS = 1 << IDX_W;

  logic [BYTE_W-1:0] cells [ROWS];

  always_ff @(posedge clk) begin
    if (we) cells[idx] <= d;
  end

  assign q = cells[idx];

endmodule

// File: rtl/endian_byte_mem.sv
module endian_byte_mem
  import emem_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_rd,
  input  logic              req_wr,
  input  logic              req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  input  logic              big_endian,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_err
);

  localparam int unsigned IDX_W = ADDR_W - LANE_W;

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  acc_size_e                    size_e;
  logic                         rd_ok, wr_ok, fault;
  logic [LANES-1:0]             bank_we;
  logic [LANES-1:0][BYTE_W-1:0] bank_d, bank_q;
  logic [WORD_W-1:0]            rd_word;
  logic [IDX_W-1:0]             row;

  assign size_e = acc_size_e'(req_size);
  assign row    = req_addr[ADDR_W-1:LANE_W];

  emem_align_chk u_align (
    .req_rd   (req_rd),
    .req_wr   (req_wr),
    .req_size (size_e),
    .addr_lo  (req_addr[LANE_W-1:0]),
    .rd_ok    (rd_ok),
    .wr_ok    (wr_ok),
    .fault    (fault)
  );

  emem_lane_map u_lanes (
    .req_size (size_e),
    .big      (big_endian),
    .lane     (req_addr[LANE_W-1:0]),
    .wr_ok    (wr_ok),
    .wdata    (req_wdata),
    .bank_q   (bank_q),
    .bank_we  (bank_we),
    .bank_d   (bank_d),
    .rd_word  (rd_word)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_bank
    emem_bank #(.IDX_W(IDX_W)) u_bank (
      .clk (clk),
      .we  (bank_we[g]),
      .idx (row),
      .d   (bank_d[g]),
      .q   (bank_q[g])
    );
  end

  // Response next-state
  logic [WORD_W-1:0] rdata_d;
  logic              rdata_en;
  logic              err_d;

  always_comb begin
    rdata_en = req_rd;
    rdata_d  = rd_ok ? rd_word : '0;
    err_d    = fault;
  end

  // Response registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      if (rdata_en) rsp_rdata <= rdata_d;
      rsp_err <= err_d;
    end
  end

  // Checks
  logic bad_word;
  assign bad_word = req_size && (req_addr[LANE_W-1:0] != '0);

  p_fault_flags_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    ((req_rd || req_wr) && bad_word) |=> rsp_err);

  p_fault_no_store_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    fault |-> (bank_we == '0));

  p_clean_no_err_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    !((req_rd || req_wr) && bad_word) |=> !rsp_err);

  p_fault_read_zero_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    (req_rd && bad_word) |=> (rsp_rdata == '0));

  p_byte_zero_ext_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    (req_rd && !req_size) |=> (rsp_rdata[31:8] == '0));

  p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    !req_rd |=> $stable(rsp_rdata));

endmodule

// File: tb/tb_endian_byte_mem.sv
module tb_endian_byte_mem;

  localparam int AW    = 6;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_rd, req_wr, req_size, big_endian;
  logic [AW-1:0] req_addr;
  logic [31:0]   req_wdata;
  logic [31:0]   rsp_rdata;
  logic          rsp_err;

  int vectors     = 0;
  int miscompares = 0;

  logic [7:0]  mdl [DEPTH];
  logic [31:0] exp_rdata;
  logic        exp_err;

  always #4 clk = ~clk;

  endian_byte_mem #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .req_rd(req_rd), .req_wr(req_wr),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .big_endian(big_endian), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err)
  );

  function automatic logic [31:0] model_word(input int a, input logic big);
    logic [31:0] v;
    for (int k = 0; k < 4; k++) begin
      if (big) v[31-8*k -: 8] = mdl[a+k];
      else     v[8*k +: 8]    = mdl[a+k];
    end
    return v;
  endfunction

  task automatic compare(input string req);
    vectors++;
    if (rsp_rdata !== exp_rdata || rsp_err !== exp_err) begin
      miscompares++;
      $display("FAIL %s: rdata=%h err=%b expected rdata=%h err=%b",
               req, rsp_rdata, rsp_err, exp_rdata, exp_err);
    end
  endtask

  // Called on a falling edge; returns on the next falling edge, having checked outputs.
  task automatic step(input logic rd, input logic wr, input logic sz, input int addr,
                      input logic [31:0] wd, input logic big, input string req);
    logic bad;
    bad        = sz && (addr % 4 != 0);
    req_rd     = rd;
    req_wr     = wr;
    req_size   = sz;
    req_addr   = AW'(addr);
    req_wdata  = wd;
    big_endian = big;
    if (rd) exp_rdata = bad ? 32'h0 : (sz ? model_word(addr, big) : {24'h0, mdl[addr]});
    exp_err = (rd || wr) && bad;
    @(posedge clk);
    if (wr && !bad) begin
      if (sz) begin
        for (int k = 0; k < 4; k++)
          mdl[addr+k] = big ? wd[31-8*k -: 8] : wd[8*k +: 8];
      end else begin
        mdl[addr] = wd[7:0];
      end
    end
    @(negedge clk);
    compare(req);
  endtask

  initial begin
    #(8 * 60000);
    miscompares++;
    $display("FAIL watchdog: run hung, actual=timeout expected=completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_rd = 0; req_wr = 0; req_size = 0; big_endian = 0;
    req_addr = '0; req_wdata = '0;
    exp_rdata = 32'h0; exp_err = 1'b0;
    repeat (3) @(negedge clk);
    compare("R11");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    compare("R11");

    // Fill: little-endian words so each byte equals its own address (R3, R1)
    for (int i = 0; i < DEPTH / 4; i++)
      step(0, 1, 1, 4*i, 32'h03020100 + 32'h04040404 * i, 0, "R3");

    step(1, 0, 1, 8, 32'h0, 0, "R3");        // 0b0a0908
    step(1, 0, 1, 8, 32'h0, 1, "R10");       // 08090a0b
    for (int k = 0; k < 4; k++) step(1, 0, 0, 8 + k, 32'h0, k[0], "R6");

    // Big-endian placement
    step(0, 1, 1, 16, 32'hDEADBEEF, 1, "R2");
    for (int k = 0; k < 4; k++) step(1, 0, 0, 16 + k, 32'h0, 0, "R2");
    step(1, 0, 1, 16, 32'h0, 0, "R10");      // efbeadde

    // Little-endian placement
    step(0, 1, 1, 20, 32'hCAFEF00D, 0, "R3");
    for (int k = 0; k < 4; k++) step(1, 0, 0, 20 + k, 32'h0, 1, "R3");

    // Misalignment faults
    step(0, 1, 1, 17, 32'h11223344, 1, "R4");
    step(1, 0, 1, 16, 32'h0, 1, "R4");       // unchanged DEADBEEF
    step(1, 0, 1, 18, 32'h0, 0, "R5");
    step(1, 0, 1, 19, 32'h0, 1, "R5");       // back-to-back fault
    step(0, 1, 1, 21, 32'hFFFFFFFF, 0, "R4");
    step(0, 0, 0, 0, 32'h0, 0, "R4");        // flag drops
    step(1, 0, 1, 20, 32'h0, 0, "R4");

    // Byte writes touch one byte only, whatever the mode
    step(0, 1, 0, 33, 32'hFFFFFFA5, 1, "R7");
    step(0, 1, 0, 34, 32'h0000005A, 0, "R12");
    step(1, 0, 1, 32, 32'h0, 1, "R7");
    step(1, 0, 1, 32, 32'h0, 0, "R12");
    step(1, 0, 0, 33, 32'h0, 0, "R12");
    step(1, 0, 0, 33, 32'h0, 1, "R12");

    // Hold across idle cycles
    step(1, 0, 1, 36, 32'h0, 1, "R8");
    step(0, 0, 0, 0, 32'h0, 0, "R8");
    step(0, 1, 1, 36, 32'h0BADF00D, 0, "R8");
    step(0, 0, 1, 3, 32'h0, 1, "R8");

    // Same-cycle read and write
    step(1, 1, 1, 40, 32'h12345678, 1, "R9");
    step(1, 0, 1, 40, 32'h0, 1, "R9");
    step(1, 1, 0, 43, 32'h000000C3, 0, "R9");
    step(1, 0, 0, 43, 32'h0, 0, "R9");

    // Mixed traffic
    for (int i = 0; i < 400; i++) begin
      logic rd, wr, sz, big;
      int   a;
      rd  = 1'($urandom_range(0, 1));
      wr  = 1'($urandom_range(0, 1));
      sz  = 1'($urandom_range(0, 1));
      big = 1'($urandom_range(0, 1));
      a   = $urandom_range(0, DEPTH - 1);
      if (sz && $urandom_range(0, 3) != 0) a = a & ~3;
      step(rd, wr, sz, a, $urandom, big, "R1");
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule